// File: doc/BRIEF.md
# Host Bridge Outbound Window Register File

This block holds the control registers of a PCI host bridge and turns a CPU-side offset into one of three outbound memory windows into a PCI bus address. The CPU reaches eight 32-bit registers through a simple port with write strobe, read strobe, byte address, byte enables and data. Read data comes back one cycle after the read strobe. The block flags a write that falls on no register or that is narrower than 32 bits, and otherwise ignores it.

A second, purely combinational port takes a window number and a local offset. It returns the PCI address and an out-of-range flag. A board-variant strap selects how each window's mapping register forms the window base. With the strap low, the low nibble of the register supplies PCI address bits [31:28]. With the strap high, the register is masked by the window size, which is a power of two. The two variants also use different window sizes. The target map, identity and flag registers are plain storage for the rest of the bridge.

Top module: `pcib_window_regs`

## Requirements
- R1: While rst_ni is low and after its release, all eight registers read as zero, reg_rdata_o is zero and reg_err_o is low.
- R2: The register index is reg_addr_i[4:2]. Index 0, 1 and 2 are the window 0, 1 and 2 mapping registers, index 3 is the bridge identity, index 4 is the flags word, and index 5, 6 and 7 are target maps 0, 1 and 2. A full write stores all 32 bits and a later read returns them.
- R3: reg_rdata_o changes only on the clock edge that samples reg_rd_i high, and holds its value in every other cycle.
- R4: An access is mapped only when reg_be_i is 4'hF, reg_addr_i[1:0] is 0 and reg_addr_i is at most 0x1C. A read that is not mapped returns zero.
- R5: A write that is not mapped changes no register, and reg_err_o is high for exactly the cycle after it.
- R6: With variant_i low, the base of window w is {map_w[3:0], 28'h0}, and the window sizes are 0x0C000000, 0x10000000 and 0x10000000.
- R7: With variant_i high, the base of window w is map_w AND NOT (size_w - 1), and the window sizes are 0x01000000, 0x04000000 and 0x08000000.
- R8: xl_addr_o is the selected window's base plus xl_off_i, modulo 2^32.
- R9: xl_oor_o is high when xl_off_i is greater than or equal to the selected window's size. Window number 3 gives xl_oor_o high and xl_addr_o zero.
- R10: A write to a mapping register changes the translation result from the cycle after the write edge.
- R11: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 1 | Board strap: 0 uses the nibble base, 1 uses the size-masked base |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_be_i | input | 4 | Byte enables; only 4'hF is a valid access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| reg_err_o | output | 1 | One-cycle pulse after a write that is not mapped |
| xl_win_i | input | 2 | Window number for translation |
| xl_off_i | input | 32 | Local offset within the window |
| xl_addr_o | output | 32 | Translated PCI address |
| xl_oor_o | output | 1 | Offset outside the window, or window number not present |

## Verification
The hardest cases to reach from the ports sit at the edges of the translation. One is an offset exactly equal to a window size. Another is a base whose high nibble plus the offset carries past bit 31. A third is a size-masked base whose register holds bits below the mask. To reach them, the stimulus loads mapping registers with all-ones and mixed patterns. It then drives offsets of size-1, size and near 2^32 under both strap settings. Ignored writes are shown by reading the target register back after each partial-width, misaligned and out-of-map write. A reference model is compared with every output on every clock, and its expected values are built from the requirements, not from the RTL.

// File: rtl/pcib_win_pkg.sv
package pcib_win_pkg;
  parameter int unsigned REG_COUNT = 8;
  parameter int unsigned WIN_COUNT = 3;
  // window sizes, entry 0 in the low word
  parameter logic [WIN_COUNT-1:0][31:0] PRI_SIZES = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000};
  parameter logic [WIN_COUNT-1:0][31:0] ALT_SIZES = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000};
endpackage

// File: rtl/pcib_reg_bank.sv
module pcib_reg_bank #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NREG    = 8,
  parameter int unsigned NUM_WIN = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic                              rd_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W/8-1:0]               be_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic                              err_o,
  output logic [NUM_WIN-1:0][DATA_W-1:0]    map_o
);
  localparam int unsigned IDX_W = $clog2(NREG);

  logic [NREG-1:0][DATA_W-1:0] regs_q;
  logic [IDX_W-1:0]            idx;
  logic                        hit;

  assign idx = addr_i[IDX_W+1:2];
  assign hit = (addr_i[1:0] == 2'b00) && ((addr_i >> (IDX_W + 2)) == '0) && (be_i == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q  <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= wr_i && !hit;
      if (rd_i) rdata_o <= hit ? regs_q[idx] : '0;  // old value wins on same-cycle write
      if (wr_i && hit) regs_q[idx] <= wdata_i;
    end
  end

  assign map_o = regs_q[NUM_WIN-1:0];

  assert_rdata_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
  assert_unmapped_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && !hit) |-> (rdata_o == '0));
  assert_bad_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && !hit) |-> $stable(regs_q));
endmodule

// File: rtl/pcib_win_xlate.sv
module pcib_win_xlate #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned WIN_W   = 2,
  parameter int unsigned NIB_W   = 4,
  parameter logic [NUM_WIN-1:0][DATA_W-1:0] PRI_SIZE = '0,
  parameter logic [NUM_WIN-1:0][DATA_W-1:0] ALT_SIZE = '0
) (
  input  logic                           alt_i,
  input  logic [NUM_WIN-1:0][DATA_W-1:0] map_i,
  input  logic [WIN_W-1:0]               win_i,
  input  logic [DATA_W-1:0]              off_i,
  output logic [DATA_W-1:0]              addr_o,
  output logic                           oor_o
);
  localparam int unsigned ALT_LOW0 = $clog2(ALT_SIZE[0]);
  localparam int unsigned PRI_LOW  = DATA_W - NIB_W;

  logic [NUM_WIN-1:0][DATA_W-1:0] base;
  logic [NUM_WIN-1:0][DATA_W-1:0] size;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign size[w] = alt_i ? ALT_SIZE[w] : PRI_SIZE[w];
    assign base[w] = alt_i ? (map_i[w] & ~(ALT_SIZE[w] - 1'b1))
                           : {map_i[w][NIB_W-1:0], {PRI_LOW{1'b0}}};
  end

  always_comb begin
    addr_o = '0;
    oor_o  = 1'b1;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (int'(win_i) == w) begin
        addr_o = base[w] + off_i;
        oor_o  = off_i >= size[w];
      end
    end
  end

  always_comb begin
    if (!alt_i && int'(win_i) < NUM_WIN)
      assert_primary_low_R6: assert (addr_o[PRI_LOW-1:0] == off_i[PRI_LOW-1:0]);
    if (alt_i && win_i == '0)
      assert_alt_low_R7: assert (addr_o[ALT_LOW0-1:0] == off_i[ALT_LOW0-1:0]);
    if (int'(win_i) >= NUM_WIN)
      assert_badwin_R9: assert (oor_o && addr_o == '0);
  end
endmodule

// File: rtl/pcib_window_regs.sv
module pcib_window_regs
  import pcib_win_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NIB_W   = 4,
  parameter logic [WIN_COUNT-1:0][31:0] PRI_SIZE = PRI_SIZES,
  parameter logic [WIN_COUNT-1:0][31:0] ALT_SIZE = ALT_SIZES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_err_o,
  input  logic [1:0]        xl_win_i,
  input  logic [DATA_W-1:0] xl_off_i,
  output logic [DATA_W-1:0] xl_addr_o,
  output logic              xl_oor_o
);
  logic [WIN_COUNT-1:0][DATA_W-1:0] map;

  pcib_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(REG_COUNT), .NUM_WIN(WIN_COUNT)
  ) i_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .be_i(reg_be_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .err_o(reg_err_o), .map_o(map)
  );

  pcib_win_xlate #(
    .DATA_W(DATA_W), .NUM_WIN(WIN_COUNT), .WIN_W(2), .NIB_W(NIB_W),
    .PRI_SIZE(PRI_SIZE), .ALT_SIZE(ALT_SIZE)
  ) i_xlate (
    .alt_i(variant_i), .map_i(map), .win_i(xl_win_i), .off_i(xl_off_i),
    .addr_o(xl_addr_o), .oor_o(xl_oor_o)
  );
endmodule

// File: tb/test_pcib_window_regs.sv
module test_pcib_window_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        variant = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [1:0]  win = '0;
  logic [31:0] off = '0;
  logic [31:0] xaddr;
  logic        oor;

  always #10 clk = ~clk;

  pcib_window_regs i_pcib_window_regs (
    .clk_i(clk), .rst_ni(rst_ni), .variant_i(variant),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_err_o(err),
    .xl_win_i(win), .xl_off_i(off), .xl_addr_o(xaddr), .xl_oor_o(oor)
  );

  int    vectors = 0, miscompares = 0;
  string tag = "R1";
  logic [31:0] m_reg [8];
  logic [31:0] m_rdata = '0;
  logic        m_err = 1'b0;

  function automatic bit m_hit(logic [7:0] a, logic [3:0] b);
    return a[1:0] == 2'b00 && a <= 8'h1C && b == 4'hF;
  endfunction

  function automatic logic [31:0] m_size(bit alt, int w);
    if (alt) return (w == 0) ? 32'h0100_0000 : (w == 1) ? 32'h0400_0000 : 32'h0800_0000;
    return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
  endfunction

  function automatic logic [31:0] m_base(bit alt, int w);
    if (alt) return m_reg[w] & ~(m_size(alt, w) - 32'd1);
    return m_reg[w] << 28;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("rdata R3", rdata, m_rdata);
    chk("err R5", {31'd0, err}, {31'd0, m_err});
    if (win < 2'd3) begin
      chk("xl addr R8", xaddr, m_base(variant, int'(win)) + off);
      chk("xl oor R9", {31'd0, oor}, {31'd0, off >= m_size(variant, int'(win))});
    end else begin
      chk("xl addr R9", xaddr, 32'd0);
      chk("xl oor R9", {31'd0, oor}, 32'd1);
    end
  endtask

  task automatic cycle(bit w_, bit r_, logic [7:0] a, logic [3:0] b, logic [31:0] d,
                       logic [1:0] wn, logic [31:0] o);
    logic [31:0] nrd;
    wr = w_; rd = r_; addr = a; be = b; wdata = d; win = wn; off = o;
    @(posedge clk); #1;
    if (rst_ni) begin
      nrd = r_ ? (m_hit(a, b) ? m_reg[a[4:2]] : 32'd0) : m_rdata;
      m_err = w_ && !m_hit(a, b);
      if (w_ && m_hit(a, b)) m_reg[a[4:2]] = d;
      m_rdata = nrd;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d); cycle(1, 0, a, 4'hF, d, 0, 0); endtask
  task automatic rreg(logic [7:0] a);                 cycle(0, 1, a, 4'hF, 0, 0, 0); endtask
  task automatic xl(logic [1:0] wn, logic [31:0] o);  cycle(0, 0, 0, 0, 0, wn, o); endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    tag = "R1";
    repeat (3) cycle(0, 0, 0, 0, 0, 0, 32'h10);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) rreg(8'(i * 4));

    tag = "R2";
    for (int i = 0; i < 8; i++) wreg(8'(i * 4), 32'hA5C3_0000 ^ (32'h1111_1111 * i) ^ 32'(i));
    for (int i = 7; i >= 0; i--) rreg(8'(i * 4));

    tag = "R4";
    rreg(8'h20); rreg(8'hFC); rreg(8'h02); rreg(8'h11);
    cycle(0, 1, 8'h04, 4'h3, 0, 0, 0);
    rreg(8'h04);

    tag = "R5";
    wreg(8'h24, 32'hDEAD_BEEF); rreg(8'h00);
    wreg(8'h05, 32'hDEAD_BEEF); rreg(8'h04);
    cycle(1, 0, 8'h00, 4'h1, 32'hFFFF_FFFF, 0, 0); rreg(8'h00);
    cycle(1, 0, 8'h10, 4'hE, 32'h0, 0, 0); rreg(8'h10);

    tag = "R11";
    cycle(1, 1, 8'h10, 4'hF, 32'h0BAD_F00D, 0, 0);
    rreg(8'h10);

    tag = "R6";
    variant = 1'b0;
    wreg(8'h00, 32'h0000_0003); wreg(8'h04, 32'hFFFF_FFF8); wreg(8'h08, 32'h0000_000F);
    for (int w = 0; w < 4; w++) begin
      xl(2'(w), 0); xl(2'(w), 32'h0BFF_FFFF); xl(2'(w), 32'h0C00_0000);
      xl(2'(w), 32'h0FFF_FFFF); xl(2'(w), 32'h1000_0000); xl(2'(w), 32'hFFFF_FFFF);
    end

    tag = "R7";
    variant = 1'b1;
    wreg(8'h00, 32'h1234_5678); wreg(8'h04, 32'hFFFF_FFFF); wreg(8'h08, 32'h8F00_00FF);
    for (int w = 0; w < 4; w++) begin
      xl(2'(w), 0); xl(2'(w), 32'h00FF_FFFF); xl(2'(w), 32'h0100_0000);
      xl(2'(w), 32'h03FF_FFFF); xl(2'(w), 32'h0400_0000);
      xl(2'(w), 32'h07FF_FFFF); xl(2'(w), 32'h0800_0000); xl(2'(w), 32'hF000_0001);
    end

    tag = "R10";
    for (int v = 0; v < 2; v++) begin
      variant = 1'(v);
      cycle(1, 0, 8'h04, 4'hF, 32'hA000_0005, 2'd1, 32'h0000_1234);
      xl(2'd1, 32'h0000_1234);
      cycle(1, 0, 8'h04, 4'hF, 32'h5000_000A, 2'd1, 32'h0000_1234);
      xl(2'd1, 32'h0000_1234);
    end

    tag = "R8";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:28] == 4'h0) variant = ~variant;
      cycle(r[0], r[1], {2'b0, r[9:4]}, r[2] ? 4'hF : r[13:10], $urandom,
            r[15:14], r[3] ? $urandom : m_size(variant, int'(r[15:14] % 3)) - 32'd1 + 32'(r[17:16]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule